// File: doc/BRIEF.md
# Triangular Carry-Merge Stage for a Pipelined Signed Multiplier

This block is the last stage of a pipelined signed array multiplier. The adder array above it leaves the upper part of the product as two redundant vectors: a sum vector and a carry vector, each `IN_W` bits wide. This block merges them into an `IN_W+1`-bit binary result. Bit 0 of `out_res` has weight 2^8 in the full 16-bit product, and bit 7 has weight 2^15.

The merge is done by a triangle of half-adder levels, not by a lookahead or ripple adder. Level L XORs the two vectors and moves the AND of each column one place to the left. After level L, the lowest L columns are final. Eight levels are needed for an 8-bit result. Each register stage holds two levels, so the merge takes four clock cycles. A column that is already final only rides through the stage registers, which act as its deskew path. All result bits therefore leave in the same cycle, together with a valid flag.

The two correction ones needed for signed two's complement multiplication are added inside the array:
- The weight-2^15 one is fed as a constant 1 into the top column. That column is made of XOR-only edge cells and never produces a carry.
- The weight-2^8 one is absorbed by the first cell of column 0. That cell outputs the XNOR of its inputs as the sum and their OR as the carry.

A new pair may be presented every clock.

Top module: `csa_merge_tri`

## Requirements
- R1: When `out_valid` is high, `out_res` equals (`in_sum` + `in_carry` + 1 + 2^(OUT_W-1)) mod 2^OUT_W. The inputs are read as unsigned, `in_sum`/`in_carry` bit 0 and `out_res` bit 0 share the lowest weight, and OUT_W = IN_W+1 = 8 by default.
- R2: A pair sampled on a rising edge with `in_valid` high appears on `out_res` with `out_valid` high just after the third rising edge that follows the sampling edge. That is four register stages.
- R3: Pairs presented on consecutive clocks give results on consecutive clocks, in the same order.
- R4: While `rst_n` is low, `out_valid` is low. Pairs in flight when reset is applied are discarded: `out_valid` stays low for the first four rising edges after release unless new pairs arrive.
- R5: `out_res[0]` is the XNOR of `in_sum[0]` and `in_carry[0]`.
- R6: A carry out of the top result bit is dropped. With all-ones inputs, the result is 0x7F for the default width.
- R7: With both inputs zero, only the two correction ones remain, so the result is 0x81 for the default width.
- R8: `out_valid` is `in_valid` delayed by four cycles. A cycle with `in_valid` low gives a cycle with `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the current sum/carry pair as valid |
| in_sum | input | IN_W | Redundant sum vector from the adder array |
| in_carry | input | IN_W | Redundant carry vector from the adder array |
| out_valid | output | 1 | Marks `out_res` as valid |
| out_res | output | IN_W+1 | Merged upper product bits |

## Verification
The hardest case to reach is a carry that rises through every level of the triangle. Only such a carry exercises the dropped carry at the top edge and the XNOR/OR corner cell in the same pass. The stimulus reaches it with all-ones vectors, and with pairs such as 0x7F plus 0 and 0x40 plus 0x40, which wrap the result to zero or near zero. Reset is also asserted while pairs are still in the pipeline, to show that they never reach the output.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

    // Role of one half-adder slot in the triangle
    typedef enum logic [1:0] {
        CELL_PASS,    // column already final: slot is a deskew register
        CELL_HA,      // plain half-adder
        CELL_HA_SET   // half-adder that also absorbs a constant one
    } cell_kind_e;

    // Level is 1-based; column 0 is the least significant result bit
    function automatic cell_kind_e kind_of(int level, int col);
        if (level == 1 && col == 0) return CELL_HA_SET;
        if (col < level - 1)        return CELL_PASS;
        return CELL_HA;
    endfunction

endpackage

// File: rtl/mrg_cell.sv
module mrg_cell
    import mrg_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_HA
) (
    input  logic a_i,
    input  logic b_i,
    output logic sum_o,
    output logic cy_o
);

    always_comb begin
        unique case (KIND)
            // b_i is zero in a settled column, so the xor just holds a_i
            CELL_PASS: begin
                sum_o = a_i ^ b_i;
                cy_o  = 1'b0;
            end
            CELL_HA: begin
                sum_o = a_i ^ b_i;
                cy_o  = a_i & b_i;
            end
            // a + b + 1: sum is xnor, carry is or
            CELL_HA_SET: begin
                sum_o = ~(a_i ^ b_i);
                cy_o  = a_i | b_i;
            end
            default: begin
                sum_o = a_i ^ b_i;
                cy_o  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mrg_edge.sv
module mrg_edge (
    input  logic a_i,
    input  logic b_i,
    output logic sum_o
);

    // Top column: the carry would leave the result width, so only xor
    assign sum_o = a_i ^ b_i;

endmodule

// File: rtl/mrg_level.sv
module mrg_level
    import mrg_pkg::*;
#(
    parameter int W     = 8,
    parameter int LEVEL = 1
) (
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] c_i,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);

    logic [W-2:0] cy;

    for (genvar j = 0; j < W - 1; j++) begin : g_col
        mrg_cell #(
            .KIND (kind_of(LEVEL, j))
        ) u_cell (
            .a_i   (s_i[j]),
            .b_i   (c_i[j]),
            .sum_o (s_o[j]),
            .cy_o  (cy[j])
        );
    end

    mrg_edge u_edge (
        .a_i   (s_i[W-1]),
        .b_i   (c_i[W-1]),
        .sum_o (s_o[W-1])
    );

    // Carries move one column up; column 0 never receives one
    assign c_o = {cy, 1'b0};

endmodule

// File: rtl/mrg_stage.sv
module mrg_stage #(
    parameter int W           = 8,
    parameter int FIRST_LEVEL = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         v_i,
    input  logic [W-1:0] s_i,
    input  logic [W-1:0] c_i,
    output logic         v_o,
    output logic [W-1:0] s_o,
    output logic [W-1:0] c_o
);

    logic [W-1:0] s_mid, c_mid, s_nxt, c_nxt;

    mrg_level #(.W(W), .LEVEL(FIRST_LEVEL)) u_lo (
        .s_i (s_i),
        .c_i (c_i),
        .s_o (s_mid),
        .c_o (c_mid)
    );

    mrg_level #(.W(W), .LEVEL(FIRST_LEVEL + 1)) u_hi (
        .s_i (s_mid),
        .c_i (c_mid),
        .s_o (s_nxt),
        .c_o (c_nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_o <= 1'b0;
            s_o <= '0;
            c_o <= '0;
        end else begin
            v_o <= v_i;
            s_o <= s_nxt;
            c_o <= c_nxt;
        end
    end

endmodule

// File: rtl/csa_merge_tri.sv
module csa_merge_tri #(
    parameter  int IN_W  = 7,
    localparam int OUT_W = IN_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_sum,
    input  logic [IN_W-1:0]  in_carry,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_res
);

    localparam int LEVELS = OUT_W;
    localparam int STAGES = (LEVELS + 1) / 2;

    logic [OUT_W-1:0] st_s [0:STAGES];
    logic [OUT_W-1:0] st_c [0:STAGES];
    logic             st_v [0:STAGES];
    logic [OUT_W-1:0] carry_left;

    // Top-weight correction one enters as a constant sum bit
    assign st_s[0] = {1'b1, in_sum};
    assign st_c[0] = {1'b0, in_carry};
    assign st_v[0] = in_valid;

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        mrg_stage #(
            .W           (OUT_W),
            .FIRST_LEVEL (2 * k + 1)
        ) u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .v_i   (st_v[k]),
            .s_i   (st_s[k]),
            .c_i   (st_c[k]),
            .v_o   (st_v[k+1]),
            .s_o   (st_s[k+1]),
            .c_o   (st_c[k+1])
        );
    end

    assign out_res    = st_s[STAGES];
    assign out_valid  = st_v[STAGES];
    assign carry_left = st_c[STAGES];

endmodule

// File: rtl/mrg_chk.sv
module mrg_chk #(
    parameter int IN_W = 7
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [IN_W-1:0] in_sum,
    input logic [IN_W-1:0] in_carry,
    input logic            out_valid,
    input logic [IN_W:0]   out_res,
    input logic [IN_W:0]   carry_left
);

    localparam int OUT_W = IN_W + 1;
    localparam int DEPTH = (OUT_W + 1) / 2;

    logic [OUT_W-1:0] ref_now;
    logic [OUT_W-1:0] ref_q  [0:DEPTH-1];
    logic             v_q    [0:DEPTH-1];
    logic             lo_q   [0:DEPTH-1];
    logic             ones_q [0:DEPTH-1];

    assign ref_now = OUT_W'(in_sum) + OUT_W'(in_carry) + OUT_W'(1)
                   + (OUT_W'(1) << (OUT_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                ref_q[i]  <= '0;
                v_q[i]    <= 1'b0;
                lo_q[i]   <= 1'b0;
                ones_q[i] <= 1'b0;
            end
        end else begin
            ref_q[0]  <= ref_now;
            v_q[0]    <= in_valid;
            lo_q[0]   <= ~(in_sum[0] ^ in_carry[0]);
            ones_q[0] <= (&in_sum) & (&in_carry);
            for (int i = 1; i < DEPTH; i++) begin
                ref_q[i]  <= ref_q[i-1];
                v_q[i]    <= v_q[i-1];
                lo_q[i]   <= lo_q[i-1];
                ones_q[i] <= ones_q[i-1];
            end
        end
    end

    AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_res == ref_q[DEPTH-1]));                      // R1

    AST_CARRY_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (carry_left == '0));                               // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |-> (out_valid == v_q[DEPTH-1]));                           // R2

    AST_IDLE_IN_RESET: assert property (@(posedge clk)
        !rst_n |-> !out_valid);                                          // R4

    AST_LOW_BIT_XNOR: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_res[0] == lo_q[DEPTH-1]));                    // R5

    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ones_q[DEPTH-1]) |-> (out_res == {1'b0, {IN_W{1'b1}}})); // R6

endmodule

bind csa_merge_tri mrg_chk #(.IN_W(IN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sum     (in_sum),
    .in_carry   (in_carry),
    .out_valid  (out_valid),
    .out_res    (out_res),
    .carry_left (carry_left)
);

// File: tb/sim_csa_merge_tri.sv
module sim_csa_merge_tri;

    localparam int IN_W  = 7;
    localparam int OUT_W = 8;
    localparam int HIST  = 1024;

    // {sum, carry, expected}
    localparam logic [21:0] VEC [0:9] = '{
        {7'h00, 7'h00, 8'h81},
        {7'h7F, 7'h7F, 8'h7F},
        {7'h01, 7'h00, 8'h82},
        {7'h40, 7'h40, 8'h01},
        {7'h7F, 7'h00, 8'h00},
        {7'h55, 7'h55, 8'h2B},
        {7'h12, 7'h34, 8'hC7},
        {7'h01, 7'h01, 8'h83},
        {7'h7F, 7'h01, 8'h01},
        {7'h3C, 7'h0F, 8'hCC}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic [IN_W-1:0]  in_sum, in_carry;
    logic             out_valid;
    logic [OUT_W-1:0] out_res;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    logic             exp_v [0:HIST-1];
    logic [OUT_W-1:0] exp_d [0:HIST-1];
    string            exp_t [0:HIST-1];

    always #10 clk = ~clk;

    csa_merge_tri #(.IN_W(IN_W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sum    (in_sum),
        .in_carry  (in_carry),
        .out_valid (out_valid),
        .out_res   (out_res)
    );

    function automatic logic [OUT_W-1:0] model(logic [IN_W-1:0] s, logic [IN_W-1:0] c);
        logic [OUT_W:0] t;
        t = (OUT_W+1)'(s) + (OUT_W+1)'(c) + (OUT_W+1)'(129);
        return t[OUT_W-1:0];
    endfunction

    task automatic chk(string tag, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Drive at a falling edge; check the output one cycle on
    task automatic step(logic v, logic [IN_W-1:0] s, logic [IN_W-1:0] c,
                        logic [OUT_W-1:0] e, string tag);
        int k;
        in_valid = v;
        in_sum   = s;
        in_carry = c;
        exp_v[cyc % HIST] = v;
        exp_d[cyc % HIST] = e;
        exp_t[cyc % HIST] = tag;
        @(posedge clk);
        @(negedge clk);
        cyc++;
        if (cyc < 4) begin
            chk("R4", OUT_W'(out_valid), '0);
        end else begin
            k = (cyc - 4) % HIST;
            chk(exp_t[k], OUT_W'(out_valid), OUT_W'(exp_v[k]));
            if (exp_v[k]) chk(exp_t[k], out_res, exp_d[k]);
        end
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, tag);
    endtask

    initial begin
        logic [IN_W-1:0] rs, rc;
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_sum   = '0;
        in_carry = '0;
        // R4: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R4", OUT_W'(out_valid), '0);
        end
        rst_n = 1'b1;
        cyc   = 0;

        // Vector table, back to back (R1, R6, R7)
        for (int i = 0; i < 10; i++) begin
            step(1'b1, VEC[i][21:15], VEC[i][14:8], VEC[i][7:0],
                 (i == 0) ? "R7" : (i == 1) ? "R6" : "R1");
        end
        idle(4, "R8");

        // R5: every low-bit combination under random upper bits
        for (int i = 0; i < 4; i++) begin
            rs = IN_W'($urandom);
            rc = IN_W'($urandom);
            rs[0] = i[0];
            rc[0] = i[1];
            step(1'b1, rs, rc, model(rs, rc), "R5");
        end
        idle(4, "R5");

        // R2: a lone pair after idle cycles
        step(1'b1, 7'h2A, 7'h15, model(7'h2A, 7'h15), "R2");
        idle(6, "R2");

        // R8: bubbles between valid pairs
        for (int i = 0; i < 12; i++) begin
            rs = IN_W'($urandom);
            rc = IN_W'($urandom);
            step(i[0] == 1'b0, rs, rc, model(rs, rc), "R8");
        end
        idle(4, "R8");

        // R3: long back-to-back random stream
        for (int i = 0; i < 300; i++) begin
            rs = IN_W'($urandom);
            rc = IN_W'($urandom);
            step(1'b1, rs, rc, model(rs, rc), "R3");
        end
        idle(4, "R3");

        // R4: reset with pairs in flight
        step(1'b1, 7'h7F, 7'h7F, 8'h7F, "R4");
        step(1'b1, 7'h11, 7'h22, model(7'h11, 7'h22), "R4");
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk("R4", OUT_W'(out_valid), '0);
        end
        rst_n = 1'b1;
        cyc   = 0;
        idle(6, "R4");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule